// File: doc/BRIEF.md
# Memory-to-Stream DMA Channel

This block is the source side of a DMA channel. Software programs a word-aligned start address (a 32-bit low part and a 17-bit upper part), a control word and, last, a byte count. Writing the byte count starts the transfer. The channel then fetches one 32-bit word at a time over a simple request/response memory port and presents each word on a valid/ready stream.

After every word the stream accepts, the channel lowers the remaining count by four bytes. It also advances the address by four bytes, unless fixed-address mode holds it still. Optionally, the four bytes of each word are reversed before output. Every word fetched from memory is added into a 32-bit checksum register that software can seed. The stream's end-of-packet marker goes out with the final word only when software asked for it when starting.

The channel reports four events as one-cycle pulses for a separate interrupt block:
- transfer done;
- memory side done;
- read error (the transfer carries on past it);
- a start written while the channel is still busy.

Top module: `m2s_dma_engine`

## Requirements
- R1: After reset `busy`, `memReq`, `strmValid` and all event outputs are 0, and every register reads back 0. The register offsets on `regWrAddr`/`regRdAddr` are: 0 address low, 1 address upper, 2 byte count, 3 control, 4 checksum.
- R2: The address-low register keeps only bits 31:2 (bits 1:0 read as 0). The upper register keeps bits 16:0. `memAddr` is {upper, low}, a 49-bit byte address.
- R3: The byte-count register keeps bits 28:2. Bit 0 of a count write is stored as the end-of-packet request and reads back in bit 0. Bits 31:29 and bit 1 read as 0.
- R4: A nonzero count written while idle sets `busy` in the next cycle and fetches words starting at the programmed address.
- R5: A count of zero written while idle leaves `busy` at 0 and pulses `evDone` and `evMemDone` for one cycle, in the cycle after the write.
- R6: Each word accepted by the stream lowers the count by 4 and raises the address by 4, with a carry into the upper part. When control bit 22 is set, the address stays constant.
- R7: In the cycle after the final word is accepted, `busy` is 0 and `evDone` and `evMemDone` pulse together for one cycle.
- R8: `strmLast` is 1 only with the final word of a transfer, and only when count bit 0 was set at the start.
- R9: When control bit 23 is set, the output word is the fetched word with its bytes reversed ({b0,b1,b2,b3}).
- R10: Each fetched word is added, modulo 2^32, into the checksum before any byte reversal. A write to offset 4 sets the checksum.
- R11: While control bit 0 or bit 1 (pause) is set, `memReq` stays 0. Clearing both resumes the transfer.
- R12: A fetch that returns `memRspErr` still delivers its word and counts it as moved. `evRdErr` pulses once, in the cycle after the response.
- R13: A count write while `busy` is 1 leaves the count register unchanged and pulses `evBadAccess` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | 3 | Register write offset |
| regWrData | input | 32 | Register write data |
| regRdAddr | input | 3 | Register read offset |
| regRdData | output | 32 | Register read data (combinational) |
| memReq | output | 1 | Read request, held until the response |
| memAddr | output | 49 | Byte address of the read |
| memRspValid | input | 1 | Read response valid |
| memRspData | input | 32 | Read response data |
| memRspErr | input | 1 | Read response error flag |
| strmValid | output | 1 | Stream word valid |
| strmReady | input | 1 | Stream sink ready |
| strmData | output | 32 | Stream word |
| strmLast | output | 1 | End-of-packet marker |
| busy | output | 1 | Transfer in progress |
| evDone | output | 1 | Transfer done pulse |
| evMemDone | output | 1 | Memory side done pulse |
| evRdErr | output | 1 | Read error pulse |
| evBadAccess | output | 1 | Count written while busy pulse |

## Verification
The hardest cases to reach from the ports are those that need the channel to stay busy while software acts on it. These are a count write that must be refused, and pause bits that must hold off fetches while a transfer is pending. The bench starts a transfer with a pause bit set, so the channel stays busy with no memory traffic. While it is held there, the bench writes a second count, reads the count register back and watches `memReq`. It then clears the pause and lets the scoreboard check the words that follow. The address carry into the upper part is reached by starting just below a 4 GiB boundary. Stream backpressure comes from a ready signal that toggles every other cycle.

// File: rtl/m2s_pkg.sv
package m2s_pkg;

  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] REG_ADDR_LO = 3'd0;
  localparam logic [REG_AW-1:0] REG_ADDR_HI = 3'd1;
  localparam logic [REG_AW-1:0] REG_SIZE    = 3'd2;
  localparam logic [REG_AW-1:0] REG_CTRL    = 3'd3;
  localparam logic [REG_AW-1:0] REG_CSUM    = 3'd4;

  localparam int CTL_PAUSE_MEM  = 0;
  localparam int CTL_PAUSE_STRM = 1;
  localparam int CTL_FIXED      = 22;
  localparam int CTL_SWAP       = 23;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_PUSH
  } m2sState_t;

  typedef struct packed {
    logic loadSize;
    logic capture;
    logic advance;
  } m2sStrobe_t;

endpackage

// File: rtl/m2s_ctrl.sv
module m2s_ctrl
  import m2s_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sizeWr,
  input  logic       sizeZeroWr,
  input  logic       sizeIsFinal,
  input  logic       lastFlag,
  input  logic       paused,
  input  logic       memRspValid,
  input  logic       memRspErr,
  input  logic       strmReady,
  output m2sStrobe_t strobe,
  output logic       busy,
  output logic       memReq,
  output logic       strmValid,
  output logic       strmLast,
  output logic       evDone,
  output logic       evMemDone,
  output logic       evRdErr,
  output logic       evBadAccess
);

  m2sState_t stateQ;

  always_comb begin
    busy            = (stateQ != ST_IDLE);
    memReq          = (stateQ == ST_FETCH) && !paused;
    strmValid       = (stateQ == ST_PUSH);
    strmLast        = strmValid && lastFlag && sizeIsFinal;
    strobe.loadSize = sizeWr && (stateQ == ST_IDLE);
    strobe.capture  = memReq && memRspValid;
    strobe.advance  = strmValid && strmReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ      <= ST_IDLE;
      evDone      <= 1'b0;
      evMemDone   <= 1'b0;
      evRdErr     <= 1'b0;
      evBadAccess <= 1'b0;
    end else begin
      evDone      <= 1'b0;
      evMemDone   <= 1'b0;
      evRdErr     <= 1'b0;
      evBadAccess <= sizeWr && (stateQ != ST_IDLE);
      case (stateQ)
        ST_IDLE: begin
          if (strobe.loadSize) begin
            if (sizeZeroWr) begin
              evDone    <= 1'b1;
              evMemDone <= 1'b1;
            end else begin
              stateQ <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (strobe.capture) begin
            evRdErr <= memRspErr;
            stateQ  <= ST_PUSH;
          end
        end
        ST_PUSH: begin
          if (strobe.advance) begin
            if (sizeIsFinal) begin
              evDone    <= 1'b1;
              evMemDone <= 1'b1;
              stateQ    <= ST_IDLE;
            end else begin
              stateQ <= ST_FETCH;
            end
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  // R11
  pause_blocks_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    paused |-> !memReq);

  // R4
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sizeWr && !busy && !sizeZeroWr) |=> busy);

  // R5
  zero_size_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sizeWr && !busy && sizeZeroWr) |=> (evDone && evMemDone && !busy));

  // R7
  finish_events_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (evDone && evMemDone));

  // R13
  busy_write_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sizeWr && busy) |=> evBadAccess);

endmodule

// File: rtl/m2s_datapath.sv
module m2s_datapath
  import m2s_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int LO_W    = 32,
  parameter int HI_W    = 17,
  parameter int SIZE_HI = 28,
  localparam int WADDR_W = LO_W - 2 + HI_W,
  localparam int SIZE_W  = SIZE_HI - 1,
  localparam int NBYTES  = DATA_W / 8
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [REG_AW-1:0]    regWrAddr,
  input  logic [DATA_W-1:0]    regWrData,
  input  logic [REG_AW-1:0]    regRdAddr,
  output logic [DATA_W-1:0]    regRdData,
  input  m2sStrobe_t           strobe,
  input  logic [DATA_W-1:0]    memRspData,
  output logic [WADDR_W+1:0]   memAddr,
  output logic [DATA_W-1:0]    strmData,
  output logic                 sizeZeroWr,
  output logic                 sizeIsFinal,
  output logic                 lastFlag,
  output logic                 paused
);

  logic [WADDR_W-1:0] wordAddrQ;
  logic [SIZE_W-1:0]  sizeQ;
  logic               lastFlagQ;
  logic               fixedQ, swapQ, pauseMemQ, pauseStrmQ;
  logic [DATA_W-1:0]  csumQ;
  logic [DATA_W-1:0]  wordQ;
  logic [DATA_W-1:0]  swapped;
  logic               addrWr;

  genvar gi;
  generate
    for (gi = 0; gi < NBYTES; gi++) begin : g_rev
      assign swapped[8*gi +: 8] = memRspData[8*(NBYTES-1-gi) +: 8];
    end
  endgenerate

  assign addrWr      = regWrEn && ((regWrAddr == REG_ADDR_LO) || (regWrAddr == REG_ADDR_HI));
  assign sizeZeroWr  = (regWrData[SIZE_HI:2] == '0);
  assign sizeIsFinal = (sizeQ == SIZE_W'(1));
  assign lastFlag    = lastFlagQ;
  assign paused      = pauseMemQ || pauseStrmQ;
  assign memAddr     = {wordAddrQ, 2'b00};
  assign strmData    = wordQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordAddrQ  <= '0;
      sizeQ      <= '0;
      lastFlagQ  <= 1'b0;
      fixedQ     <= 1'b0;
      swapQ      <= 1'b0;
      pauseMemQ  <= 1'b0;
      pauseStrmQ <= 1'b0;
      csumQ      <= '0;
      wordQ      <= '0;
    end else begin
      if (regWrEn && regWrAddr == REG_ADDR_LO)
        wordAddrQ[LO_W-3:0] <= regWrData[LO_W-1:2];
      if (regWrEn && regWrAddr == REG_ADDR_HI)
        wordAddrQ[WADDR_W-1 -: HI_W] <= regWrData[HI_W-1:0];
      if (regWrEn && regWrAddr == REG_CTRL) begin
        pauseMemQ  <= regWrData[CTL_PAUSE_MEM];
        pauseStrmQ <= regWrData[CTL_PAUSE_STRM];
        fixedQ     <= regWrData[CTL_FIXED];
        swapQ      <= regWrData[CTL_SWAP];
      end
      if (strobe.loadSize) begin
        sizeQ     <= regWrData[SIZE_HI:2];
        lastFlagQ <= regWrData[0];
      end
      if (strobe.capture) begin
        wordQ <= swapQ ? swapped : memRspData;
        csumQ <= csumQ + memRspData;
      end
      if (regWrEn && regWrAddr == REG_CSUM)
        csumQ <= regWrData;
      if (strobe.advance) begin
        sizeQ <= sizeQ - SIZE_W'(1);
        if (!fixedQ && !addrWr)
          wordAddrQ <= wordAddrQ + WADDR_W'(1);
      end
    end
  end

  always_comb begin
    regRdData = '0;
    case (regRdAddr)
      REG_ADDR_LO: regRdData = DATA_W'({wordAddrQ[LO_W-3:0], 2'b00});
      REG_ADDR_HI: regRdData = DATA_W'(wordAddrQ[WADDR_W-1 -: HI_W]);
      REG_SIZE:    regRdData = DATA_W'({sizeQ, 1'b0, lastFlagQ});
      REG_CTRL: begin
        regRdData[CTL_PAUSE_MEM]  = pauseMemQ;
        regRdData[CTL_PAUSE_STRM] = pauseStrmQ;
        regRdData[CTL_FIXED]      = fixedQ;
        regRdData[CTL_SWAP]       = swapQ;
      end
      REG_CSUM:    regRdData = csumQ;
      default:     regRdData = '0;
    endcase
  end

  // R6
  size_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> (sizeQ == $past(sizeQ) - SIZE_W'(1)));

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !fixedQ && !addrWr) |=> (memAddr == $past(memAddr) + (WADDR_W+2)'(4)));

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && fixedQ && !addrWr) |=> $stable(memAddr));

endmodule

// File: rtl/m2s_dma_engine.sv
module m2s_dma_engine
  import m2s_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [2:0]  regWrAddr,
  input  logic [31:0] regWrData,
  input  logic [2:0]  regRdAddr,
  output logic [31:0] regRdData,
  output logic        memReq,
  output logic [48:0] memAddr,
  input  logic        memRspValid,
  input  logic [31:0] memRspData,
  input  logic        memRspErr,
  output logic        strmValid,
  input  logic        strmReady,
  output logic [31:0] strmData,
  output logic        strmLast,
  output logic        busy,
  output logic        evDone,
  output logic        evMemDone,
  output logic        evRdErr,
  output logic        evBadAccess
);

  m2sStrobe_t strobe;
  logic       sizeWr, sizeZeroWr, sizeIsFinal, lastFlag, paused;

  assign sizeWr = regWrEn && (regWrAddr == REG_SIZE);

  m2s_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sizeWr(sizeWr), .sizeZeroWr(sizeZeroWr),
    .sizeIsFinal(sizeIsFinal), .lastFlag(lastFlag), .paused(paused),
    .memRspValid(memRspValid), .memRspErr(memRspErr), .strmReady(strmReady),
    .strobe(strobe), .busy(busy), .memReq(memReq), .strmValid(strmValid),
    .strmLast(strmLast), .evDone(evDone), .evMemDone(evMemDone),
    .evRdErr(evRdErr), .evBadAccess(evBadAccess)
  );

  m2s_datapath #(.DATA_W(32), .LO_W(32), .HI_W(17), .SIZE_HI(28)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .strobe(strobe), .memRspData(memRspData), .memAddr(memAddr),
    .strmData(strmData), .sizeZeroWr(sizeZeroWr), .sizeIsFinal(sizeIsFinal),
    .lastFlag(lastFlag), .paused(paused)
  );

  // R8
  last_with_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strmLast && strmReady) |=> !busy);

  // R12
  err_one_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    evRdErr |=> !evRdErr);

endmodule

// File: tb/m2s_dma_engine_tb.sv
module m2s_dma_engine_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regWrAddr = '0;
  logic [31:0] regWrData = '0;
  logic [2:0]  regRdAddr = '0;
  logic [31:0] regRdData;
  logic        memReq;
  logic [48:0] memAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        memRspErr = 1'b0;
  logic        strmValid;
  logic        strmReady = 1'b0;
  logic [31:0] strmData;
  logic        strmLast;
  logic        busy, evDone, evMemDone, evRdErr, evBadAccess;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int readyMode = 1;
  logic [48:0] errAddr = '1;
  int doneCnt = 0, memDoneCnt = 0, rdErrCnt = 0, lastCnt = 0, reqWhilePaused = 0;
  logic [32:0] expQ[$];
  logic [31:0] expCsum = '0;
  logic        summaryDone = 1'b0;

  always #5 clk = ~clk;

  m2s_dma_engine u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .memReq(memReq), .memAddr(memAddr), .memRspValid(memRspValid),
    .memRspData(memRspData), .memRspErr(memRspErr), .strmValid(strmValid),
    .strmReady(strmReady), .strmData(strmData), .strmLast(strmLast),
    .busy(busy), .evDone(evDone), .evMemDone(evMemDone), .evRdErr(evRdErr),
    .evBadAccess(evBadAccess)
  );

  function automatic logic [31:0] memFn(input logic [48:0] a);
    return a[31:0] * 32'h0100_0193 + {15'd0, a[48:32]} + 32'h1357_9BDF;
  endfunction

  function automatic logic [31:0] rev(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // memory model: answers one cycle after a request is seen
  always @(posedge clk) begin
    cyc <= cyc + 1;
    memRspValid <= memReq && !memRspValid;
    memRspData  <= memFn(memAddr);
    memRspErr   <= memReq && !memRspValid && (memAddr == errAddr);
    case (readyMode)
      0: strmReady <= 1'b0;
      1: strmReady <= 1'b1;
      default: strmReady <= cyc[0];
    endcase
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (evDone) doneCnt++;
      if (evMemDone) memDoneCnt++;
      if (evRdErr) rdErrCnt++;
      if (memReq && u_dut_paused_view) reqWhilePaused++;
      if (strmValid && strmReady) begin
        if (strmLast) lastCnt++;
        if (expQ.size() == 0) begin
          check("R4 unexpected word", {31'd0, strmLast, strmData}, 64'h0);
        end else begin
          logic [32:0] e;
          e = expQ.pop_front();
          check("R9/R8 stream word", {31'd0, strmLast, strmData}, {31'd0, e});
        end
      end
    end
  end

  // pause state as programmed by the bench (tracked on the bench side)
  logic u_dut_paused_view = 1'b0;

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrAddr = a; regWrData = d;
    if (a == 3'd3) u_dut_paused_view = d[0] | d[1];
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    regRdAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic pushExp(input logic [48:0] start, input int n, input bit lastF,
                         input bit fixed, input bit swap);
    for (int i = 0; i < n; i++) begin
      logic [48:0] a;
      logic [31:0] raw;
      a = fixed ? start : start + 49'(4 * i);
      raw = memFn(a);
      expCsum = expCsum + raw;
      expQ.push_back({lastF && (i == n - 1), swap ? rev(raw) : raw});
    end
  endtask

  task automatic waitDone(input int target);
    int guard = 0;
    while (doneCnt < target && guard < 3000) begin
      @(negedge clk); #1;
      guard++;
    end
  endtask

  initial begin
    while (cyc < 100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    if (!summaryDone) begin
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 memReq", memReq, 0);
    check("R1 strmValid", strmValid, 0);
    check("R1 events", {evDone, evMemDone, evRdErr, evBadAccess}, 0);
    for (int r = 0; r < 5; r++) begin
      regRead(3'(r), d);
      check("R1 register", d, 0);
    end

    // R2 address alignment and upper part
    regWrite(3'd0, 32'h1234_5677);
    regRead(3'd0, d); check("R2 low aligned", d, 32'h1234_5674);
    regWrite(3'd1, 32'hFFFF_FFFF);
    regRead(3'd1, d); check("R2 upper 17 bits", d, 32'h0001_FFFF);
    check("R2 memAddr", memAddr, 49'h1_FFFF_1234_5674);

    // R3/R11/R13: start paused, reject a second start, then resume
    regWrite(3'd0, 32'h0000_1000);
    regWrite(3'd1, 32'h0);
    regWrite(3'd4, 32'h0);
    expCsum = 0;
    regWrite(3'd3, 32'h0000_0001);
    pushExp(49'h1000, 4, 1'b1, 1'b0, 1'b0);
    regWrite(3'd2, 32'hE000_0013);
    regRead(3'd2, d); check("R3 size readback", d, 32'h0000_0011);
    check("R4 busy after start", busy, 1);
    repeat (20) @(negedge clk);
    check("R11 no request while paused", reqWhilePaused, 0);
    check("R11 no word while paused", strmValid, 0);
    regWrite(3'd2, 32'h0000_0008);
    check("R13 bad access pulse", evBadAccess, 1);
    regRead(3'd2, d); check("R13 size unchanged", d, 32'h0000_0011);
    regWrite(3'd3, 32'h0000_0002);
    repeat (10) @(negedge clk);
    check("R11 stream pause bit also blocks", reqWhilePaused, 0);
    regWrite(3'd3, 32'h0);
    waitDone(1);
    check("R7 done count", doneCnt, 1);
    check("R7 mem done count", memDoneCnt, 1);
    check("R7 busy cleared", busy, 0);
    check("R8 last seen once", lastCnt, 1);
    regRead(3'd4, d); check("R10 checksum", d, expCsum);
    regRead(3'd0, d); check("R6 address advanced", d, 32'h0000_1010);

    // R6 carry into upper part, no end-of-packet (R8)
    regWrite(3'd0, 32'hFFFF_FFF8);
    regWrite(3'd1, 32'h3);
    pushExp(49'h3_FFFF_FFF8, 4, 1'b0, 1'b0, 1'b0);
    regWrite(3'd2, 32'h0000_0010);
    waitDone(2);
    check("R6 carry low", doneCnt, 2);
    regRead(3'd0, d); check("R6 low after carry", d, 32'h0000_0008);
    regRead(3'd1, d); check("R6 upper after carry", d, 32'h0000_0004);
    check("R8 no last without flag", lastCnt, 1);
    regRead(3'd2, d); check("R6 size at zero", d, 32'h0);

    // R9/R10 byte reversal with backpressure and seeded checksum
    readyMode = 2;
    regWrite(3'd4, 32'hDEAD_0000);
    expCsum = 32'hDEAD_0000;
    regWrite(3'd3, 32'h0080_0000);
    regWrite(3'd0, 32'h0000_2000);
    regWrite(3'd1, 32'h0);
    pushExp(49'h2000, 5, 1'b1, 1'b0, 1'b1);
    regWrite(3'd2, 32'h0000_0015);
    waitDone(3);
    check("R9 done", doneCnt, 3);
    regRead(3'd4, d); check("R10 checksum before reversal", d, expCsum);
    check("R8 last second time", lastCnt, 2);

    // R6 fixed address mode
    readyMode = 1;
    regWrite(3'd3, 32'h0040_0000);
    regWrite(3'd0, 32'h0000_3000);
    pushExp(49'h3000, 3, 1'b0, 1'b1, 1'b0);
    regWrite(3'd2, 32'h0000_000C);
    waitDone(4);
    regRead(3'd0, d); check("R6 fixed address held", d, 32'h0000_3000);

    // R5 zero size
    regWrite(3'd3, 32'h0);
    regWrite(3'd2, 32'h0000_0000);
    check("R5 done pulse", {evDone, evMemDone}, 2'b11);
    check("R5 not busy", busy, 0);
    @(negedge clk);
    check("R5 single pulse", {evDone, evMemDone}, 2'b00);

    // R12 read error in the middle
    expCsum = 0;
    regWrite(3'd4, 32'h0);
    regWrite(3'd0, 32'h0000_4000);
    errAddr = 49'h4004;
    pushExp(49'h4000, 3, 1'b0, 1'b0, 1'b0);
    regWrite(3'd2, 32'h0000_000C);
    waitDone(6);
    check("R12 error pulse count", rdErrCnt, 1);
    check("R12 transfer completed", doneCnt, 6);
    regRead(3'd0, d); check("R12 word counted", d, 32'h0000_400C);
    regRead(3'd4, d); check("R12 checksum", d, expCsum);

    repeat (5) @(negedge clk);
    check("scoreboard drained", expQ.size(), 0);

    summaryDone = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule